// File: doc/BRIEF.md
# EEPROM Byte Access and Record Boot Loader

This block sits between a host register port and an external byte-wide EEPROM. Through a small register set the host can fetch or store one EEPROM byte at a time. It can also start a burst that walks a chain of records held in the EEPROM and copies their payload bytes into on-chip memory. The EEPROM is reached through a request/response byte port. On-chip memory is reached through a byte write port. Both data ports use valid/ready flow control.

Each record carries a 16-bit target word (low byte first), then a length byte N, then N payload bytes. The memory address of the first payload byte joins a 9-bit base register (upper bits) with the low 15 bits of the target word. Bit 15 of that word is dropped. The remaining payload bytes go to the next higher addresses. A record whose length is 0 ends the burst.

The burst does not always start at address 0. It starts at 0 only when nothing has touched the EEPROM since reset. Otherwise it starts just after the last byte that was accessed. Software can therefore load a chain in several steps.

Top module: `eeprom_boot_ctrl`

## Requirements
- R1: After reset every register reads 0, and `ee_req_valid` and `mem_valid` are low. The register indices on `reg_addr` are: 0 control, 1 EEPROM address, 2 data, 3 base, 4 burst start. Any other index reads 0.
- R2: Writing the control register with bit 1 set while idle reads the EEPROM at the address register. When the byte returns, it is placed in data bits [7:0], and control bit 1 (which reads 1 while the fetch runs) reads 0.
- R3: Writing the control register with bit 0 set and bit 1 clear while idle writes data bits [7:0] to the EEPROM at the address register. Control bit 0 reads 1 until the request is accepted, then reads 0.
- R4: When control bits 0 and 1 are written together, only the read runs and the EEPROM is not written.
- R5: Writes to the control register or the burst-start register while any operation is busy have no effect. No extra EEPROM access and no memory write results from them.
- R6: A burst started after reset, before any single access, fetches its first byte from EEPROM address 0.
- R7: Any other burst fetches its first byte from the address that follows the last address accessed, whether that access was a single read, a single write or the previous burst.
- R8: Writing bit 0 of the burst-start register while idle starts a burst. The burst parses records (address low byte, address high byte, length, then payload) and stops at a length of 0. Burst-start bit 0 reads 1 until the burst stops, then reads 0.
- R9: The payload byte k of a record is written to memory address ({base[8:0], word[14:0]} + k) mod 2^24. The base value is captured when the burst starts.
- R10: EEPROM addresses wrap from EE_BYTES-1 to 0. EE_BYTES must be a power of two.
- R11: `ee_req_valid`, once raised, holds with stable address, direction and write byte until `ee_req_ready`. A read's response (`ee_rsp_valid`, one cycle) must come at least one cycle after the request is accepted, and it is always taken.
- R12: `mem_valid` holds with stable address and data until `mem_ready`. A low `mem_ready` stalls the burst without losing or repeating bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for read and write |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Register read value for `reg_addr` (combinational) |
| ee_req_valid | output | 1 | EEPROM request valid |
| ee_req_ready | input | 1 | EEPROM request accepted |
| ee_req_we | output | 1 | 1 = write request, 0 = read request |
| ee_req_addr | output | $clog2(EE_BYTES) | EEPROM byte address |
| ee_req_wdata | output | 8 | Byte to store on a write |
| ee_rsp_valid | input | 1 | Read byte returned |
| ee_rsp_data | input | 8 | Returned byte |
| mem_valid | output | 1 | Memory write valid |
| mem_ready | input | 1 | Memory write accepted |
| mem_addr | output | 24 | Memory byte address |
| mem_data | output | 8 | Memory byte |

## Verification
A corrupted next-access pointer does not show at once. It shows at the start of the next burst, as a payload sent to a wrong address or as a chain that ends early. For that reason every burst in the bench begins where the previous operation left off.

A bad record-field state shows within the same record, as a wrong `mem_addr` on the first payload byte or as a wrong byte count. Lost flow-control holds show in the same cycle as a changed request or memory word while its ready is low. Both data ports are stalled on irregular patterns throughout the run.

// File: rtl/ebl_pkg.sv
package ebl_pkg;
  localparam logic [2:0] RIX_CTRL  = 3'd0;
  localparam logic [2:0] RIX_ADDR  = 3'd1;
  localparam logic [2:0] RIX_DATA  = 3'd2;
  localparam logic [2:0] RIX_BASE  = 3'd3;
  localparam logic [2:0] RIX_START = 3'd4;

  typedef enum logic [2:0] {
    EG_IDLE,
    EG_SRD_REQ,
    EG_SRD_WAIT,
    EG_SWR_REQ,
    EG_B_REQ,
    EG_B_WAIT,
    EG_B_MEM
  } eng_state_e;

  typedef enum logic [1:0] {
    FLD_ALO,
    FLD_AHI,
    FLD_LEN,
    FLD_DAT
  } rec_field_e;
endpackage

// File: rtl/ebl_addr_form.sv
module ebl_addr_form #(
  parameter int BASE_W = 9,
  parameter int LOW_W  = 15,
  parameter int OFF_W  = 8
) (
  input  logic [BASE_W-1:0]       base,
  input  logic [LOW_W-1:0]        low,
  input  logic [OFF_W-1:0]        off,
  output logic [BASE_W+LOW_W-1:0] addr
);
  localparam int AW = BASE_W + LOW_W;

  // Base and EEPROM-supplied bits are concatenated, then the payload offset is added.
  assign addr = {base, low} + {{(AW-OFF_W){1'b0}}, off};
endmodule

// File: rtl/ebl_regs.sv
module ebl_regs
  import ebl_pkg::*;
#(
  parameter int EE_AW  = 11,
  parameter int BASE_W = 9,
  parameter int REG_DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              busy_rd,
  input  logic              busy_wr,
  input  logic              busy_burst,
  input  logic              rd_done,
  input  logic [7:0]        rd_byte,
  output logic              cmd_read,
  output logic              cmd_write,
  output logic              cmd_burst,
  output logic [EE_AW-1:0]  ee_addr,
  output logic [7:0]        wr_byte,
  output logic [BASE_W-1:0] base
);
  logic idle;
  logic wr_ctrl, wr_start;
  logic unused_wdata;

  assign idle     = !(busy_rd || busy_wr || busy_burst);
  assign wr_ctrl  = reg_wr_en && (reg_addr == RIX_CTRL);
  assign wr_start = reg_wr_en && (reg_addr == RIX_START);

  // Commands are accepted only from idle; read wins over write.
  assign cmd_read  = wr_ctrl && idle && reg_wdata[1];
  assign cmd_write = wr_ctrl && idle && reg_wdata[0] && !reg_wdata[1];
  assign cmd_burst = wr_start && idle && reg_wdata[0];

  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ee_addr <= '0;
      wr_byte <= '0;
      base    <= '0;
    end else begin
      if (reg_wr_en && reg_addr == RIX_ADDR) ee_addr <= reg_wdata[EE_AW-1:0];
      if (reg_wr_en && reg_addr == RIX_BASE) base <= reg_wdata[BASE_W-1:0];
      if (rd_done) wr_byte <= rd_byte;
      else if (reg_wr_en && reg_addr == RIX_DATA) wr_byte <= reg_wdata[7:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RIX_CTRL:  reg_rdata[1:0] = {busy_rd, busy_wr};
      RIX_ADDR:  reg_rdata[EE_AW-1:0] = ee_addr;
      RIX_DATA:  reg_rdata[7:0] = wr_byte;
      RIX_BASE:  reg_rdata[BASE_W-1:0] = base;
      RIX_START: reg_rdata[0] = busy_burst;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ebl_engine.sv
module ebl_engine
  import ebl_pkg::*;
#(
  parameter int EE_AW  = 11,
  parameter int BASE_W = 9,
  parameter int LOW_W  = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_read,
  input  logic                    cmd_write,
  input  logic                    cmd_burst,
  input  logic [EE_AW-1:0]        ee_addr,
  input  logic [7:0]              wr_byte,
  input  logic [BASE_W-1:0]       base,
  output logic                    busy_rd,
  output logic                    busy_wr,
  output logic                    busy_burst,
  output logic                    rd_done,
  output logic [7:0]              rd_byte,
  output logic                    ee_req_valid,
  input  logic                    ee_req_ready,
  output logic                    ee_req_we,
  output logic [EE_AW-1:0]        ee_req_addr,
  output logic [7:0]              ee_req_wdata,
  input  logic                    ee_rsp_valid,
  input  logic [7:0]              ee_rsp_data,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic [BASE_W+LOW_W-1:0] mem_addr,
  output logic [7:0]              mem_data
);
  localparam int HI_W  = LOW_W - 8;
  localparam int CNT_W = 8;

  eng_state_e        state;
  rec_field_e        fld;
  logic [EE_AW-1:0]  cur, ptr, cur_nxt;
  logic [7:0]        lo_q, dbuf, wbuf;
  logic [HI_W-1:0]   hi_q;
  logic [CNT_W-1:0]  remain, offset;
  logic [BASE_W-1:0] bbase;

  assign cur_nxt = cur + {{(EE_AW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= EG_IDLE;
      fld    <= FLD_ALO;
      cur    <= '0;
      ptr    <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      dbuf   <= '0;
      wbuf   <= '0;
      remain <= '0;
      offset <= '0;
      bbase  <= '0;
    end else begin
      case (state)
        EG_IDLE: begin
          if (cmd_read) begin
            cur   <= ee_addr;
            state <= EG_SRD_REQ;
          end else if (cmd_write) begin
            cur   <= ee_addr;
            wbuf  <= wr_byte;
            state <= EG_SWR_REQ;
          end else if (cmd_burst) begin
            cur   <= ptr;
            bbase <= base;
            fld   <= FLD_ALO;
            state <= EG_B_REQ;
          end
        end
        EG_SRD_REQ: if (ee_req_ready) state <= EG_SRD_WAIT;
        EG_SRD_WAIT: begin
          if (ee_rsp_valid) begin
            ptr   <= cur_nxt;
            state <= EG_IDLE;
          end
        end
        EG_SWR_REQ: begin
          if (ee_req_ready) begin
            ptr   <= cur_nxt;
            state <= EG_IDLE;
          end
        end
        EG_B_REQ: if (ee_req_ready) state <= EG_B_WAIT;
        EG_B_WAIT: begin
          if (ee_rsp_valid) begin
            cur <= cur_nxt;
            ptr <= cur_nxt;
            case (fld)
              FLD_ALO: begin
                lo_q  <= ee_rsp_data;
                fld   <= FLD_AHI;
                state <= EG_B_REQ;
              end
              FLD_AHI: begin
                hi_q  <= ee_rsp_data[HI_W-1:0];
                fld   <= FLD_LEN;
                state <= EG_B_REQ;
              end
              FLD_LEN: begin
                if (ee_rsp_data == 8'd0) begin
                  state <= EG_IDLE;
                end else begin
                  remain <= ee_rsp_data;
                  offset <= '0;
                  fld    <= FLD_DAT;
                  state  <= EG_B_REQ;
                end
              end
              default: begin
                dbuf  <= ee_rsp_data;
                state <= EG_B_MEM;
              end
            endcase
          end
        end
        EG_B_MEM: begin
          if (mem_ready) begin
            offset <= offset + 1'b1;
            remain <= remain - 1'b1;
            if (remain == 8'd1) fld <= FLD_ALO;
            state <= EG_B_REQ;
          end
        end
        default: state <= EG_IDLE;
      endcase
    end
  end

  assign busy_rd    = (state == EG_SRD_REQ) || (state == EG_SRD_WAIT);
  assign busy_wr    = (state == EG_SWR_REQ);
  assign busy_burst = (state == EG_B_REQ) || (state == EG_B_WAIT) || (state == EG_B_MEM);

  assign rd_done = (state == EG_SRD_WAIT) && ee_rsp_valid;
  assign rd_byte = ee_rsp_data;

  assign ee_req_valid = (state == EG_SRD_REQ) || (state == EG_SWR_REQ) || (state == EG_B_REQ);
  assign ee_req_we    = (state == EG_SWR_REQ);
  assign ee_req_addr  = cur;
  assign ee_req_wdata = wbuf;

  assign mem_valid = (state == EG_B_MEM);
  assign mem_data  = dbuf;

  ebl_addr_form #(
    .BASE_W(BASE_W),
    .LOW_W (LOW_W),
    .OFF_W (CNT_W)
  ) u_form (
    .base(bbase),
    .low ({hi_q, lo_q}),
    .off (offset),
    .addr(mem_addr)
  );
endmodule

// File: rtl/eeprom_boot_ctrl.sv
module eeprom_boot_ctrl #(
  parameter int EE_BYTES = 2048,
  localparam int EE_AW   = $clog2(EE_BYTES),
  localparam int BASE_W  = 9,
  localparam int LOW_W   = 15,
  localparam int MEM_AW  = BASE_W + LOW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              ee_req_valid,
  input  logic              ee_req_ready,
  output logic              ee_req_we,
  output logic [EE_AW-1:0]  ee_req_addr,
  output logic [7:0]        ee_req_wdata,
  input  logic              ee_rsp_valid,
  input  logic [7:0]        ee_rsp_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_data
);
  logic              busy_rd, busy_wr, busy_burst;
  logic              rd_done;
  logic [7:0]        rd_byte;
  logic              cmd_read, cmd_write, cmd_burst;
  logic [EE_AW-1:0]  ee_addr;
  logic [7:0]        wr_byte;
  logic [BASE_W-1:0] base;

  ebl_regs #(
    .EE_AW (EE_AW),
    .BASE_W(BASE_W),
    .REG_DW(32)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy_rd   (busy_rd),
    .busy_wr   (busy_wr),
    .busy_burst(busy_burst),
    .rd_done   (rd_done),
    .rd_byte   (rd_byte),
    .cmd_read  (cmd_read),
    .cmd_write (cmd_write),
    .cmd_burst (cmd_burst),
    .ee_addr   (ee_addr),
    .wr_byte   (wr_byte),
    .base      (base)
  );

  ebl_engine #(
    .EE_AW (EE_AW),
    .BASE_W(BASE_W),
    .LOW_W (LOW_W)
  ) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_read    (cmd_read),
    .cmd_write   (cmd_write),
    .cmd_burst   (cmd_burst),
    .ee_addr     (ee_addr),
    .wr_byte     (wr_byte),
    .base        (base),
    .busy_rd     (busy_rd),
    .busy_wr     (busy_wr),
    .busy_burst  (busy_burst),
    .rd_done     (rd_done),
    .rd_byte     (rd_byte),
    .ee_req_valid(ee_req_valid),
    .ee_req_ready(ee_req_ready),
    .ee_req_we   (ee_req_we),
    .ee_req_addr (ee_req_addr),
    .ee_req_wdata(ee_req_wdata),
    .ee_rsp_valid(ee_rsp_valid),
    .ee_rsp_data (ee_rsp_data),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_addr    (mem_addr),
    .mem_data    (mem_data)
  );
endmodule

// File: rtl/ebl_checker.sv
module ebl_checker #(
  parameter int EE_AW  = 11,
  parameter int MEM_AW = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [2:0]        reg_addr,
  input logic [1:0]        ctrl_bits,
  input logic              busy_rd,
  input logic              busy_wr,
  input logic              busy_burst,
  input logic              ee_req_valid,
  input logic              ee_req_ready,
  input logic              ee_req_we,
  input logic [EE_AW-1:0]  ee_req_addr,
  input logic [7:0]        ee_req_wdata,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [7:0]        mem_data
);
  logic idle;
  assign idle = !(busy_rd || busy_wr || busy_burst);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req_valid && !ee_req_ready |=> ee_req_valid && $stable(ee_req_addr)
      && $stable(ee_req_we) && $stable(ee_req_wdata));

  p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

  p_one_port_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ee_req_valid && mem_valid));

  p_one_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy_rd, busy_wr, busy_burst}));

  p_no_switch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_rd |=> !busy_wr && !busy_burst) and
    (busy_wr |=> !busy_rd && !busy_burst) and
    (busy_burst |=> !busy_rd && !busy_wr));

  p_read_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && reg_addr == 3'd0 && ctrl_bits[1] && idle |=> busy_rd);

  p_write_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req_valid && busy_wr |-> ee_req_we);

  p_burst_reads_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req_valid && busy_burst |-> !ee_req_we);

  p_mem_in_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy_burst);
endmodule

bind eeprom_boot_ctrl ebl_checker #(
  .EE_AW (EE_AW),
  .MEM_AW(MEM_AW)
) u_ebl_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_addr    (reg_addr),
  .ctrl_bits   (reg_wdata[1:0]),
  .busy_rd     (busy_rd),
  .busy_wr     (busy_wr),
  .busy_burst  (busy_burst),
  .ee_req_valid(ee_req_valid),
  .ee_req_ready(ee_req_ready),
  .ee_req_we   (ee_req_we),
  .ee_req_addr (ee_req_addr),
  .ee_req_wdata(ee_req_wdata),
  .mem_valid   (mem_valid),
  .mem_ready   (mem_ready),
  .mem_addr    (mem_addr),
  .mem_data    (mem_data)
);

// File: tb/eeprom_boot_ctrl_bench.sv
module eeprom_boot_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int EE_N = 256;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic ee_req_valid, ee_req_we;
  logic [AW-1:0] ee_req_addr;
  logic [7:0] ee_req_wdata;
  logic ee_req_ready;
  logic ee_rsp_valid = 1'b0;
  logic [7:0] ee_rsp_data = 8'd0;
  logic mem_valid;
  logic mem_ready;
  logic [23:0] mem_addr;
  logic [7:0] mem_data;

  logic [7:0] ee_mem [EE_N];
  int ee_wr_cnt = 0;
  int cyc = 0;
  logic ee_ready_q = 1'b0;
  logic mem_ready_q = 1'b0;
  int exp_addr[$], exp_data[$], obs_addr[$], obs_data[$];
  int total = 0, bad = 0, wptr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign ee_req_ready = ee_ready_q;
  assign mem_ready = mem_ready_q;

  eeprom_boot_ctrl #(.EE_BYTES(EE_N)) u_eeprom_boot_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ee_req_valid(ee_req_valid), .ee_req_ready(ee_req_ready), .ee_req_we(ee_req_we),
    .ee_req_addr(ee_req_addr), .ee_req_wdata(ee_req_wdata),
    .ee_rsp_valid(ee_rsp_valid), .ee_rsp_data(ee_rsp_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  // Behavioural EEPROM and memory sink with irregular stall patterns.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    ee_ready_q <= (cyc % 3) != 2;
    mem_ready_q <= (cyc % 5) != 3;
    ee_rsp_valid <= 1'b0;
    if (rst_n && ee_req_valid && ee_req_ready) begin
      if (ee_req_we) begin
        ee_mem[ee_req_addr] = ee_req_wdata;
        ee_wr_cnt = ee_wr_cnt + 1;
      end else begin
        ee_rsp_valid <= 1'b1;
        ee_rsp_data <= ee_mem[ee_req_addr];
      end
    end
    if (rst_n && mem_valid && mem_ready) begin
      obs_addr.push_back(int'(mem_addr));
      obs_data.push_back(int'(mem_data));
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input int d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  task automatic wait_idle();
    int c, s;
    for (int i = 0; i < 3000; i++) begin
      reg_rd(3'd0, c);
      reg_rd(3'd4, s);
      if (c == 0 && s == 0) break;
    end
  endtask

  task automatic put_byte(input int b);
    ee_mem[wptr] = b[7:0];
    wptr = (wptr + 1) % EE_N;
  endtask

  task automatic put_rec(input int a16, input int n, input int base);
    put_byte(a16 & 8'hFF);
    put_byte((a16 >> 8) & 8'hFF);
    put_byte(n);
    for (int k = 0; k < n; k++) begin
      int d;
      d = (a16 + k * 29 + n * 3) & 8'hFF;
      put_byte(d);
      exp_addr.push_back((((base & 9'h1FF) << 15) + (a16 & 16'h7FFF) + k) & 24'hFFFFFF);
      exp_data.push_back(d);
    end
  endtask

  task automatic put_end();
    put_byte(0); put_byte(0); put_byte(0);
  endtask

  task automatic run_burst(input string tag);
    int s;
    obs_addr.delete(); obs_data.delete();
    reg_wr(3'd4, 1);
    reg_rd(3'd4, s);
    chk(s & 1, 1, {tag, " R8 start busy"});
    wait_idle();
    reg_rd(3'd4, s);
    chk(s, 0, {tag, " R8 start cleared"});
    chk(obs_addr.size(), exp_addr.size(), {tag, " R8 byte count"});
    for (int i = 0; i < exp_addr.size() && i < obs_addr.size(); i++) begin
      chk(obs_addr[i], exp_addr[i], {tag, " R9 mem address"});
      chk(obs_data[i], exp_data[i], {tag, " R8 R12 mem data"});
    end
    exp_addr.delete(); exp_data.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, w0;
    for (int i = 0; i < EE_N; i++) ee_mem[i] = 8'((i * 37 + 11) & 8'hFF);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    for (int r = 0; r < 8; r++) begin
      reg_rd(3'(r), v);
      chk(v, 0, "R1 register reset value");
    end
    chk(int'(ee_req_valid), 0, "R1 no eeprom request");
    chk(int'(mem_valid), 0, "R1 no memory write");

    // R6: first burst from address 0, bit 15 dropped, carry past bit 15
    wptr = 0;
    reg_wr(3'd3, 5);
    put_rec(16'h8123, 3, 5);
    put_rec(16'h7FFE, 4, 5);
    put_end();
    run_burst("R6");

    // R7: next burst continues after the previous one
    put_rec(16'h0040, 2, 5);
    put_end();
    run_burst("R7 after burst");

    // R2: read sweep over every EEPROM address
    for (int a = 0; a < EE_N; a++) begin
      reg_wr(3'd1, a);
      reg_wr(3'd0, 2);
      wait_idle();
      reg_rd(3'd2, v);
      chk(v, int'(ee_mem[a]), "R2 read data");
      reg_rd(3'd0, v);
      chk(v, 0, "R2 read bit cleared");
    end

    // R10: pointer wrapped from 0xFF to 0
    wptr = 0;
    reg_wr(3'd3, 9'h1FF);
    put_rec(16'h0100, 2, 9'h1FF);
    put_end();
    run_burst("R10 pointer wrap");

    // R10: record spanning the end of the EEPROM
    reg_wr(3'd1, 8'hFC);
    reg_wr(3'd0, 2);
    wait_idle();
    wptr = 8'hFD;
    reg_wr(3'd3, 2);
    put_rec(16'h1234, 3, 2);
    put_end();
    run_burst("R10 record wrap");

    // R3: single write, then R7 burst after it
    w0 = ee_wr_cnt;
    reg_wr(3'd1, 8'h90);
    reg_wr(3'd2, 8'hA5);
    reg_wr(3'd0, 1);
    reg_rd(3'd0, v);
    chk(v, 1, "R3 write bit busy");
    wait_idle();
    chk(int'(ee_mem[8'h90]), 8'hA5, "R3 stored byte");
    chk(ee_wr_cnt, w0 + 1, "R3 one write");
    wptr = 8'h91;
    put_rec(16'h2222, 2, 2);
    put_end();
    run_burst("R7 after write");

    // R4: both bits set -> read only
    ee_mem[8'h30] = 8'hC3;
    w0 = ee_wr_cnt;
    reg_wr(3'd1, 8'h30);
    reg_wr(3'd2, 8'h5A);
    reg_wr(3'd0, 3);
    wait_idle();
    reg_rd(3'd2, v);
    chk(v, 8'hC3, "R4 read taken");
    chk(int'(ee_mem[8'h30]), 8'hC3, "R4 no store");
    chk(ee_wr_cnt, w0, "R4 write count");

    // R5: control and start writes while a read is busy
    w0 = ee_wr_cnt;
    obs_addr.delete();
    reg_wr(3'd1, 8'h44);
    reg_wr(3'd0, 2);
    reg_wr(3'd0, 1);
    reg_wr(3'd4, 1);
    wait_idle();
    chk(ee_wr_cnt, w0, "R5 no write during read");
    chk(obs_addr.size(), 0, "R5 no burst during read");
    reg_rd(3'd2, v);
    chk(v, int'(ee_mem[8'h44]), "R5 read result intact");

    // R5: control write while a burst is busy; R7 after read at 0x44
    w0 = ee_wr_cnt;
    wptr = 8'h45;
    reg_wr(3'd3, 7);
    put_rec(16'h0abc, 3, 7);
    put_end();
    obs_addr.delete(); obs_data.delete();
    reg_wr(3'd4, 1);
    reg_wr(3'd0, 1);
    reg_wr(3'd0, 2);
    wait_idle();
    chk(ee_wr_cnt, w0, "R5 no write during burst");
    chk(obs_addr.size(), exp_addr.size(), "R5 R7 burst count");
    for (int i = 0; i < exp_addr.size() && i < obs_addr.size(); i++) begin
      chk(obs_addr[i], exp_addr[i], "R7 R9 address");
      chk(obs_data[i], exp_data[i], "R7 data");
    end
    exp_addr.delete(); exp_data.delete();

    // R9 R12: sweep of bases and lengths under memory stalls
    foreach (exp_addr[i]) exp_addr.delete();
    for (int b = 0; b < 4; b++) begin
      for (int n = 1; n <= 4; n++) begin
        int base, a16;
        base = (b * 9'h0AA + b) & 9'h1FF;
        a16 = (16'h7FFC + n * 16'h1111 + base) & 16'hFFFF;
        reg_wr(3'd3, base);
        put_rec(a16, n, base);
        put_end();
        run_burst("R9 sweep");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule